// File: doc/BRIEF.md
# Checkerboard Two-Way Cache Data Array

This block is the data store of a two-way set-associative instruction cache. Each line holds eight 32-bit instructions (256 bits). The storage is split into four 64-bit-wide sub-arrays: left-upper, left-lower, right-upper and right-lower. The two ways are interleaved across them in a checkerboard. Row `r` of a sub-array is formed from a line index and one low row bit. The left pair of sub-arrays and the right pair each get their own low row bit.

On an ordinary fetch, both sides get the same low bit. Each side then produces a candidate 64-bit instruction pair from a different way. A late way-hit select, supplied by external tag logic in the cycle the data comes out, picks one of the two. On a line access, the left and right low bits are set opposite to each other, chosen by the way number. This makes all eight instructions of one way reachable in one cycle, for either a write (line fill) or a read (line cast-out).

The fetch port is a valid/ready stream. `fetch_ready` drops in any cycle that carries a line request, so a line access always wins and the colliding fetch is simply not accepted. The output side has no back-pressure: `pair_valid` and `line_rvalid` pulse for one cycle, and the consumer must take the data then. The line request port is always ready.

Top module: `cbd_data_array`

## Requirements
- R1: While `rst_n` is low and after its release with no request pending, `pair_valid` and `line_rvalid` are low and `fetch_ready` is high.
- R2: A fetch accepted (`fetch_valid && fetch_ready`) at address `a` gives `pair_valid` high one cycle later. In that cycle, `pair_data[31:0]` holds instruction `2p` and `pair_data[63:32]` holds instruction `2p+1`, where `p = a[1:0]`. Both come from line `a[AW-1:2]` of the way named by `hit_way` as sampled in that same output cycle.
- R3: A line write (`line_valid && line_write`) stores all eight instructions of `line_wdata` (instruction `i` at bits `[32i+31:32i]`) into line `line_idx` of way `line_way` in one cycle. The other way at the same index, and all other lines, keep their contents.
- R4: A line read (`line_valid && !line_write`) gives `line_rvalid` high one cycle later. `line_rdata` then holds the line of way `line_way` in order, with instruction `i` at bits `[32i+31:32i]`.
- R5: Whenever `line_valid` is high, `fetch_ready` is low and `pair_valid` is low in the next cycle. `pair_valid` and `line_rvalid` are never high together.
- R6: Fetches accepted in consecutive cycles produce results in consecutive cycles, one pair per cycle, with no bubbles.
- R7: A cycle with no accepted fetch gives `pair_valid` low in the next cycle. A line write gives `line_rvalid` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch request |
| fetch_ready | output | 1 | Fetch accepted this cycle (low during a line request) |
| fetch_addr | input | AW | Instruction-pair address: [AW-1:2] line, [1] lower half, [0] odd row |
| hit_way | input | 1 | Way chosen by tag compare, sampled in the output cycle |
| pair_valid | output | 1 | Fetch result valid |
| pair_data | output | 64 | Selected instruction pair |
| line_valid | input | 1 | Full-line access request |
| line_write | input | 1 | 1 = write line, 0 = read line |
| line_way | input | 1 | Way of the line access |
| line_idx | input | AW-2 | Line index of the line access |
| line_wdata | input | 256 | Line to write, instruction i at [32i+31:32i] |
| line_rvalid | output | 1 | Line read result valid |
| line_rdata | output | 256 | Line read result in instruction order |

## Verification
The bench fills both ways of a reduced array with patterns whose value encodes way, line and instruction number. It then fetches every pair address under both hit selections in one unbroken stream. A placement or permutation error shows up as a word tagged with the wrong way or instruction. An error in the odd-row handling for one side shows up as half the pairs of one way carrying the other way's tag. Every line of both ways is read back whole, and one way is then rewritten alone. This exposes an unswizzle that does not invert the write permutation, and a line write that drives the wrong low row bit on one side and corrupts the other way. Collisions of a fetch with a line read and with a line write check that the fetch is refused and produces no output. They also check that the line operation still completes with its effect visible on later fetches.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
  localparam int INSTR_W = 32;
  localparam int PAIR_W  = 2 * INSTR_W;
  localparam int LINE_PAIRS = 4;
  localparam int LINE_W  = LINE_PAIRS * PAIR_W;
  localparam int N_ARR   = 4;   // index = {side, half}: side 0 left, half 0 upper

  typedef logic [PAIR_W-1:0] pair_t;
  typedef logic [LINE_W-1:0] line_t;
endpackage

// File: rtl/cbd_subarray.sv
module cbd_subarray #(
  parameter int ROWS = 2048,
  parameter int W    = 64
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic                     we,
  input  logic [$clog2(ROWS)-1:0]  row,
  input  logic [W-1:0]             wdata,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wdata;
      else    rdata    <= mem[row];
    end
  end
endmodule

// File: rtl/cbd_row_select.sv
module cbd_row_select #(
  parameter int RB = 11
) (
  input  logic                 fetch_valid,
  input  logic [RB:0]          fetch_addr,
  input  logic                 line_valid,
  input  logic                 line_write,
  input  logic                 line_way,
  input  logic [RB-2:0]        line_idx,
  output logic                 fetch_ready,
  output logic                 fetch_go,
  output logic [1:0][RB-1:0]   side_row,
  output logic [3:0]           arr_en,
  output logic [3:0]           arr_we
);
  always_comb begin
    fetch_ready = !line_valid;
    fetch_go    = fetch_valid && !line_valid;
    for (int s = 0; s < 2; s++) begin
      // line access: left low bit = way, right low bit = inverted way
      if (line_valid) side_row[s] = {line_idx, line_way ^ 1'(s)};
      else            side_row[s] = {fetch_addr[RB:2], fetch_addr[0]};
    end
    for (int a = 0; a < 4; a++) begin
      // a fetch only wakes the half that holds the requested pair
      arr_en[a] = line_valid | (fetch_go & (fetch_addr[1] == 1'(a % 2)));
      arr_we[a] = line_valid & line_write;
    end
  end
endmodule

// File: rtl/cbd_line_swizzle.sv
module cbd_line_swizzle
  import cbd_pkg::*;
(
  input  logic                     wr_way,
  input  line_t                    line_in,
  output logic [N_ARR-1:0][PAIR_W-1:0] arr_wd,
  input  logic                     rd_way,
  input  logic [N_ARR-1:0][PAIR_W-1:0] arr_rd,
  output line_t                    line_out
);
  genvar s, h, p;
  generate
    for (s = 0; s < 2; s++) begin : g_side
      for (h = 0; h < 2; h++) begin : g_half
        logic [1:0] wp;  // pair index {half, low row bit}
        assign wp = {1'(h), wr_way ^ 1'(s)};
        assign arr_wd[s*2+h] = line_in[PAIR_W*wp +: PAIR_W];
      end
    end
    for (p = 0; p < LINE_PAIRS; p++) begin : g_pair
      logic [1:0] src;  // {side, half}
      assign src = {rd_way ^ 1'(p % 2), 1'(p / 2)};
      assign line_out[PAIR_W*p +: PAIR_W] = arr_rd[src];
    end
  endgenerate
endmodule

// File: rtl/cbd_pair_select.sv
module cbd_pair_select
  import cbd_pkg::*;
(
  input  logic [N_ARR-1:0][PAIR_W-1:0] arr_rd,
  input  logic                     half_q,
  input  logic                     low_q,
  input  logic                     hit_way,
  output pair_t                    pair_data
);
  pair_t left_pair, right_pair;

  always_comb begin
    left_pair  = arr_rd[{1'b0, half_q}];
    right_pair = arr_rd[{1'b1, half_q}];
    // the left side holds the way equal to the low row bit
    pair_data  = (hit_way == low_q) ? left_pair : right_pair;
  end
endmodule

// File: rtl/cbd_data_array.sv
module cbd_data_array
  import cbd_pkg::*;
#(
  parameter int ROWS = 2048,
  localparam int RB = $clog2(ROWS),
  localparam int AW = RB + 1,
  localparam int LB = RB - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [AW-1:0]     fetch_addr,
  input  logic              hit_way,
  output logic              pair_valid,
  output logic [PAIR_W-1:0] pair_data,
  input  logic              line_valid,
  input  logic              line_write,
  input  logic              line_way,
  input  logic [LB-1:0]     line_idx,
  input  logic [LINE_W-1:0] line_wdata,
  output logic              line_rvalid,
  output logic [LINE_W-1:0] line_rdata
);
  logic                         fetch_go;
  logic [1:0][RB-1:0]           side_row;
  logic [N_ARR-1:0]             arr_en, arr_we;
  logic [N_ARR-1:0][PAIR_W-1:0] arr_wd, arr_rd;
  logic                         half_q, low_q, rway_q;
  logic                         pair_valid_q, line_rvalid_q;

  cbd_row_select #(.RB(RB)) u_rsel (
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .line_valid  (line_valid),
    .line_write  (line_write),
    .line_way    (line_way),
    .line_idx    (line_idx),
    .fetch_ready (fetch_ready),
    .fetch_go    (fetch_go),
    .side_row    (side_row),
    .arr_en      (arr_en),
    .arr_we      (arr_we)
  );

  genvar a;
  generate
    for (a = 0; a < N_ARR; a++) begin : g_arr
      cbd_subarray #(.ROWS(ROWS), .W(PAIR_W)) u_sa (
        .clk   (clk),
        .en    (arr_en[a]),
        .we    (arr_we[a]),
        .row   (side_row[a/2]),
        .wdata (arr_wd[a]),
        .rdata (arr_rd[a])
      );
    end
  endgenerate

  cbd_line_swizzle u_swz (
    .wr_way   (line_way),
    .line_in  (line_wdata),
    .arr_wd   (arr_wd),
    .rd_way   (rway_q),
    .arr_rd   (arr_rd),
    .line_out (line_rdata)
  );

  cbd_pair_select u_psel (
    .arr_rd    (arr_rd),
    .half_q    (half_q),
    .low_q     (low_q),
    .hit_way   (hit_way),
    .pair_data (pair_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_valid_q  <= 1'b0;
      line_rvalid_q <= 1'b0;
    end else begin
      pair_valid_q  <= fetch_go;
      line_rvalid_q <= line_valid & ~line_write;
    end
  end

  always_ff @(posedge clk) begin
    if (fetch_go) begin
      half_q <= fetch_addr[1];
      low_q  <= fetch_addr[0];
    end
    if (line_valid) rway_q <= line_way;
  end

  assign pair_valid  = pair_valid_q;
  assign line_rvalid = line_rvalid_q;
endmodule

// File: rtl/cbd_data_array_chk.sv
module cbd_data_array_chk (
  input logic clk,
  input logic rst_n,
  input logic fetch_valid,
  input logic fetch_ready,
  input logic pair_valid,
  input logic line_valid,
  input logic line_write,
  input logic line_rvalid
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!pair_valid && !line_rvalid));

  // R5
  line_blocks_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> !fetch_ready);

  // R5
  line_drops_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |=> !pair_valid);

  // R5
  no_dual_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pair_valid && line_rvalid));

  // R2
  fetch_gives_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready) |=> pair_valid);

  // R7
  idle_no_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !pair_valid);

  // R4
  read_gives_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && !line_write) |=> line_rvalid);

  // R7
  write_no_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && line_write) |=> !line_rvalid);
endmodule

bind cbd_data_array cbd_data_array_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_valid (fetch_valid),
  .fetch_ready (fetch_ready),
  .pair_valid  (pair_valid),
  .line_valid  (line_valid),
  .line_write  (line_write),
  .line_rvalid (line_rvalid)
);

// File: tb/cbd_data_array_bench.sv
module cbd_data_array_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS  = 16;
  localparam int RB    = 4;
  localparam int AW    = RB + 1;
  localparam int LB    = RB - 1;
  localparam int LINES = ROWS / 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           fetch_valid = 1'b0;
  logic           fetch_ready;
  logic [AW-1:0]  fetch_addr = '0;
  logic           hit_way = 1'b0;
  logic           pair_valid;
  logic [63:0]    pair_data;
  logic           line_valid = 1'b0;
  logic           line_write = 1'b0;
  logic           line_way = 1'b0;
  logic [LB-1:0]  line_idx = '0;
  logic [255:0]   line_wdata = '0;
  logic           line_rvalid;
  logic [255:0]   line_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbd_data_array #(.ROWS(ROWS)) u_cbd_data_array (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .hit_way(hit_way), .pair_valid(pair_valid), .pair_data(pair_data),
    .line_valid(line_valid), .line_write(line_write), .line_way(line_way),
    .line_idx(line_idx), .line_wdata(line_wdata),
    .line_rvalid(line_rvalid), .line_rdata(line_rdata)
  );

  function automatic logic [31:0] word(int seed, int w, int l, int i);
    return {8'(seed), 8'(w), 8'(l), 8'(i)};
  endfunction

  function automatic logic [255:0] line_pat(int seed, int w, int l);
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = word(seed, w, l, i);
    return v;
  endfunction

  function automatic logic [63:0] pair_pat(int seed, int w, int a);
    int l = a / 4;
    int p = a % 4;
    return {word(seed, w, l, 2*p+1), word(seed, w, l, 2*p)};
  endfunction

  task automatic check(bit ok, string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_line_write(int w, int l, logic [255:0] d);
    @(negedge clk);
    line_valid = 1'b1; line_write = 1'b1; line_way = 1'(w);
    line_idx = LB'(l); line_wdata = d;
    @(negedge clk);
    line_valid = 1'b0; line_write = 1'b0;
    check(!line_rvalid, "R7 write gives no rvalid", 256'(line_rvalid), 256'(0));
  endtask

  task automatic do_line_read(int w, int l, logic [255:0] exp, string req);
    @(negedge clk);
    line_valid = 1'b1; line_write = 1'b0; line_way = 1'(w); line_idx = LB'(l);
    @(negedge clk);
    line_valid = 1'b0;
    check(line_rvalid && line_rdata === exp, req, line_rdata, exp);
  endtask

  task automatic do_fetch(int a, int w, logic [63:0] exp, string req);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = AW'(a);
    @(negedge clk);
    fetch_valid = 1'b0; hit_way = 1'(w);
    #1;
    check(pair_valid && pair_data === exp, req, 256'(pair_data), 256'(exp));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!pair_valid && !line_rvalid && fetch_ready, "R1 during reset",
          256'({pair_valid, line_rvalid, fetch_ready}), 256'(3'b001));
    rst_n = 1'b1;
    @(negedge clk);
    check(!pair_valid && !line_rvalid && fetch_ready, "R1 after reset",
          256'({pair_valid, line_rvalid, fetch_ready}), 256'(3'b001));

    // R3: fill both ways
    for (int w = 0; w < 2; w++)
      for (int l = 0; l < LINES; l++)
        do_line_write(w, l, line_pat(1, w, l));

    // R2 R6: streaming sweep over every pair address under both hit selections
    for (int w = 0; w < 2; w++) begin
      for (int a = 0; a < 4*LINES; a++) begin
        @(negedge clk);
        if (a > 0) begin
          hit_way = 1'(w);
          #1;
          check(pair_valid && pair_data === pair_pat(1, w, a-1), "R2 R6 stream pair",
                256'(pair_data), 256'(pair_pat(1, w, a-1)));
        end
        fetch_valid = 1'b1; fetch_addr = AW'(a);
      end
      @(negedge clk);
      fetch_valid = 1'b0; hit_way = 1'(w);
      #1;
      check(pair_valid && pair_data === pair_pat(1, w, 4*LINES-1), "R2 R6 stream last",
            256'(pair_data), 256'(pair_pat(1, w, 4*LINES-1)));
    end

    // R7: idle cycles give no pair
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!pair_valid, "R7 idle no pair", 256'(pair_valid), 256'(0));
    end

    // R4: read every line of both ways in order
    for (int w = 0; w < 2; w++)
      for (int l = 0; l < LINES; l++)
        do_line_read(w, l, line_pat(1, w, l), "R4 line read");

    // R3: rewrite way 0 only, way 1 must be untouched
    for (int l = 0; l < LINES; l++) do_line_write(0, l, line_pat(2, 0, l));
    for (int l = 0; l < LINES; l++) do_line_read(0, l, line_pat(2, 0, l), "R3 rewritten way");
    for (int l = 0; l < LINES; l++) do_line_read(1, l, line_pat(1, 1, l), "R3 other way kept");

    // R5: fetch colliding with line read
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = AW'(5);
    line_valid = 1'b1; line_write = 1'b0; line_way = 1'b1; line_idx = LB'(3);
    #1;
    check(!fetch_ready, "R5 ready low on collision", 256'(fetch_ready), 256'(0));
    @(negedge clk);
    fetch_valid = 1'b0; line_valid = 1'b0;
    check(!pair_valid, "R5 fetch dropped vs read", 256'(pair_valid), 256'(0));
    check(line_rvalid && line_rdata === line_pat(1, 1, 3), "R5 read wins",
          line_rdata, line_pat(1, 1, 3));

    // R5: fetch colliding with line write
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = AW'(6);
    line_valid = 1'b1; line_write = 1'b1; line_way = 1'b1; line_idx = LB'(1);
    line_wdata = line_pat(3, 1, 1);
    @(negedge clk);
    fetch_valid = 1'b0; line_valid = 1'b0; line_write = 1'b0;
    check(!pair_valid && !line_rvalid, "R5 fetch dropped vs write",
          256'({pair_valid, line_rvalid}), 256'(0));
    do_fetch(6, 1, pair_pat(3, 1, 6), "R5 R3 write took effect");
    do_fetch(6, 0, pair_pat(2, 0, 6), "R3 same index other way");
    do_fetch(7, 1, pair_pat(3, 1, 7), "R2 odd row after write");
    do_fetch(13, 1, pair_pat(1, 1, 13), "R3 other line kept");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule